// File: doc/BRIEF.md
# Indexed Block-Access Register Target for SMBus

This block is a bus target for a two-wire SMBus/I2C link that answers at seven-bit address 0x69 (write byte 0xD2, read byte 0xD3). It holds a small bank of 8-bit configuration registers. Every transfer is an indexed block. A write carries a starting index and then a run of data bytes that land at consecutive indices. A read first sets the index with a short write phase, then uses a repeated start with the read address. The target answers with a byte-count header and then streams registers from that index onward.

The two bus lines are oversampled on the system clock. Start and stop are recognised from SDA edges while SCL is high. The target drives SDA only as an open-drain pull-down enable, and it changes that enable only while SCL is low. The register storage is a companion bank with a single write port and a combinational read port. Each register has its own reset value and its own mask of writable bits.

Top module: `smbus_blk_slave`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x69. After any other address byte it sends no ACK and does not pull SDA low until the next start condition.
- R2: In a write transfer (address byte 0xD2), the first byte after the address sets the index N. Each following data byte is stored at N, N+1, N+2 and so on, and the target acknowledges every byte.
- R3: After the index phase, a repeated start, and address byte 0xD3, the target sends the byte-count register (index 8) first. It then sends the registers starting at index N, with the most significant bit first.
- R4: Once as many data bytes as the count header gave have been sent, every further byte of that read is 0xFF, with SDA left released.
- R5: A NACK from the host ends the read with SDA released. A stop or start condition also always releases SDA.
- R6: Register 7 is read-only. It holds 0x01, with the vendor code 0x1 in bits 3:0 and the revision 0x0 in bits 7:4, and writes to it have no effect.
- R7: Reserved bits keep their reset value when written: bits 7:4 of register 0, bits 7:6 of register 2, all of register 5 (reset 0x00) and all of register 6 (reset 0x08).
- R8: The reset values are: register 0 = 0x00, register 1 = 0xFF, register 2 = 0x17, registers 3 and 4 = 0x00, register 8 = 0x08. SDA is released during reset.
- R9: Register 8 can be read and written. A value written to it becomes the count header and the number of data bytes in later reads.
- R10: The SDA enable changes only while SCL is low, except when a start or stop releases it. A bit the target sends stays stable through the whole SCL-high phase.
- R11: Indices at or above the bank size read as 0x00. Data bytes written to them are acknowledged but stored nowhere, and the index keeps incrementing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull-down enable for the data line; 1 drives SDA low |

## Verification
Two events can fall in the same cycle. On the SCL fall that follows the host's ACK, the target loads the next byte from the bank, increments the index and decrements the remaining count. When the count runs out on exactly the byte whose index is the first one past the bank, both the out-of-range read value and the 0xFF fill rule apply one bit time apart. The bench provokes this with a read from index 7 and a count of 3, after writing an ignored byte at index 9 in the same burst that set the count. The monitor expects 0x03, 0x01, 0x03, 0x00 and then 0xFF. A mix-up between the index and the count shows up as a wrong value in that position.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_IDX = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_INDEX,
        RX_DATA
    } rx_role_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    // power-up contents per register index
    function automatic byte_t init_val(input int i);
        case (i)
            1:       return 8'hFF;
            2:       return 8'h17;
            6:       return 8'h08;
            7:       return 8'h01;
            CNT_IDX: return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    // writable bits per register index
    function automatic byte_t wmask(input int i);
        case (i)
            0:       return 8'h0F;
            1:       return 8'hFF;
            2:       return 8'h3F;
            3, 4:    return 8'hFF;
            CNT_IDX: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync
    import smbus_blk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_s,
    output line_ev_t ev
);
    logic scl_m, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank
    import smbus_blk_pkg::*;
#(
    parameter int NREG = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  byte_t                  wr_idx,
    input  byte_t                  wr_data,
    input  byte_t                  rd_idx,
    output byte_t                  rd_data,
    output byte_t                  count_o,
    output logic [NREG*BYTE_W-1:0] snap_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t RV = init_val(g);
        localparam byte_t WM = wmask(g);
        byte_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= RV;
            else if (wr_en && wr_idx == byte_t'(g))
                q <= (q & ~WM) | (wr_data & WM);
        end
        assign snap_o[g*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == byte_t'(k))
                rd_data = snap_o[k*BYTE_W +: BYTE_W];
    end

    assign count_o = snap_o[CNT_IDX*BYTE_W +: BYTE_W];
endmodule

// File: rtl/smbus_blk_fsm.sv
module smbus_blk_fsm
    import smbus_blk_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    input  byte_t    rd_data,
    input  byte_t    count_i,
    output logic     wr_en,
    output byte_t    wr_data,
    output byte_t    idx_o,
    output logic     sda_oe,
    output logic     idle_o
);
    bus_st_e    st;
    rx_role_e   role;
    logic [3:0] bitcnt;
    byte_t      sh, idx, left;
    logic       rw, nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            role   <= RX_ADDR;
            bitcnt <= '0;
            sh     <= '0;
            idx    <= '0;
            left   <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_RX;
            role   <= RX_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.rise) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.fall && bitcnt == 4'd8) begin
                        if (role == RX_ADDR && sh[7:1] != DEV_ADDR) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_ACK;
                            sda_oe <= 1'b1;
                            case (role)
                                RX_ADDR:  rw  <= sh[0];
                                RX_INDEX: idx <= sh;
                                default:  idx <= idx + 8'd1;
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (role == RX_ADDR && rw) begin
                            st     <= ST_TX;
                            sh     <= count_i;
                            left   <= count_i;
                            sda_oe <= ~count_i[7];
                        end else begin
                            st     <= ST_RX;
                            sda_oe <= 1'b0;
                            role   <= (role == RX_ADDR) ? RX_INDEX : RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd7) begin
                            st     <= ST_RACK;
                            sda_oe <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        nack <= ev.sda;
                    end else if (ev.fall) begin
                        if (nack) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_TX;
                            bitcnt <= '0;
                            if (left != 8'd0) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                idx    <= idx + 8'd1;
                                left   <= left - 8'd1;
                            end else begin
                                sh     <= 8'hFF;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_en   = (st == ST_RX) && (role == RX_DATA) && ev.fall &&
                     (bitcnt == 4'd8) && !ev.start && !ev.stop;
    assign wr_data = sh;
    assign idx_o   = idx;
    assign idle_o  = (st == ST_IDLE);
endmodule

// File: rtl/smbus_blk_slave.sv
module smbus_blk_slave
    import smbus_blk_pkg::*;
#(
    parameter int         NREG     = 9,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    line_ev_t               line_ev;
    logic                   scl_s;
    logic                   wr_en;
    byte_t                  wr_data, idx, rd_data, count;
    logic                   bus_idle;
    logic [NREG*BYTE_W-1:0] bank_snap;

    smbus_line_sync i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .ev    (line_ev)
    );

    smbus_blk_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (line_ev),
        .rd_data (rd_data),
        .count_i (count),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .idx_o   (idx),
        .sda_oe  (sda_oe),
        .idle_o  (bus_idle)
    );

    smbus_reg_bank #(.NREG(NREG)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .count_o (count),
        .snap_o  (bank_snap)
    );
endmodule

// File: rtl/smbus_blk_chk.sv
module smbus_blk_chk #(
    parameter int NREG = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             stop_ev,
    input logic             start_ev,
    input logic             bus_idle,
    input logic             wr_en,
    input logic [NREG*8-1:0] snap
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || !sda_oe));

    // R5
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    // R5
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> !sda_oe);

    // R6
    ro_id_chk: assert property (@(posedge clk) disable iff (rst)
        snap[7*8 +: 8] == 8'h01);

    // R7
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(snap[5*8 +: 16]));

    // R2
    write_active_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bus_idle && !scl_s);
endmodule

bind smbus_blk_slave smbus_blk_chk #(.NREG(NREG)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .stop_ev  (line_ev.stop),
    .start_ev (line_ev.start),
    .bus_idle (bus_idle),
    .wr_en    (wr_en),
    .snap     (bank_snap)
);

// File: tb/test_smbus_blk_slave.sv
module test_smbus_blk_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_ln;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got;
    event       rx_ev;

    always #4 clk = ~clk;

    assign sda_ln = sda_h & ~sda_oe;

    smbus_blk_slave i_smbus_blk_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_h),
        .sda_i  (sda_ln),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic do_stop();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wait_q();
            scl_h = 1'b1; wait_q();
            scl_h = 1'b0; wait_q();
        end
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        ack = ~sda_ln;
        scl_h = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        logic early;
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_h = 1'b1;
            repeat (3) @(negedge clk);
            early = sda_ln;
            repeat (Q - 3) @(negedge clk);
            b[i] = sda_ln;
            // R10: bit held through SCL high
            chk(early == b[i], "R10 bit stable while SCL high", 8'(early), 8'(b[i]));
            scl_h = 1'b0;
        end
        wait_q();
        sda_h = last;
        wait_q();
        scl_h = 1'b1; wait_q();
        scl_h = 1'b0; wait_q();
        sda_h = 1'b1;
    endtask

    task automatic expect_b(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wr_begin(input logic [7:0] idx);
        logic a;
        do_start();
        send_byte(8'hD2, a);
        chk(a, "R1 write address acknowledged", 8'(a), 8'h1);
        send_byte(idx, a);
        chk(a, "R2 index acknowledged", 8'(a), 8'h1);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        logic a;
        send_byte(d, a);
        chk(a, "R2 data byte acknowledged", 8'(a), 8'h1);
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int n);
        logic       a;
        logic [7:0] b;
        do_start();
        send_byte(8'hD2, a);
        chk(a, "R1 write address acknowledged", 8'(a), 8'h1);
        send_byte(idx, a);
        chk(a, "R3 index acknowledged", 8'(a), 8'h1);
        do_start();
        send_byte(8'hD3, a);
        chk(a, "R3 read address acknowledged", 8'(a), 8'h1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            got = b;
            ->rx_ev;
        end
        // R5: NACK releases the line
        chk(!sda_oe, "R5 SDA released after NACK", 8'(sda_oe), 8'h0);
        do_stop();
    endtask

    // monitor: compares each received byte against the scoreboard
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard unexpected byte", got, 8'h00);
            end else begin
                logic [7:0] v;
                string      t;
                v = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got === v, t, got, v);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        // R8: released during reset
        chk(!sda_oe, "R8 SDA released in reset", 8'(sda_oe), 8'h0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // power-up contents, full default count
        expect_b(8'h08, "R8 count header reset 0x08");
        expect_b(8'h00, "R8 reg0 reset");
        expect_b(8'hFF, "R8 reg1 reset");
        expect_b(8'h17, "R8 reg2 reset");
        expect_b(8'h00, "R8 reg3 reset");
        expect_b(8'h00, "R8 reg4 reset");
        expect_b(8'h00, "R7 reg5 reset");
        expect_b(8'h08, "R7 reg6 reset");
        expect_b(8'h01, "R6 reg7 id value");
        rd_txn(8'd0, 9);

        // foreign address is ignored
        do_start();
        send_byte(8'hA4, a);
        chk(!a, "R1 foreign address not acknowledged", 8'(a), 8'h0);
        send_byte(8'h00, a);
        chk(!a, "R1 bus ignored after mismatch", 8'(a), 8'h0);
        do_stop();

        // burst write over registers 0..7
        wr_begin(8'd0);
        wr_byte(8'hFF); wr_byte(8'h55); wr_byte(8'hFF); wr_byte(8'h12);
        wr_byte(8'h34); wr_byte(8'hAA); wr_byte(8'hAA); wr_byte(8'h99);
        do_stop();
        expect_b(8'h08, "R3 count header");
        expect_b(8'h0F, "R7 reg0 reserved bits kept");
        expect_b(8'h55, "R2 reg1 written");
        expect_b(8'h3F, "R7 reg2 reserved bits kept");
        expect_b(8'h12, "R2 reg3 written");
        expect_b(8'h34, "R2 reg4 written");
        expect_b(8'h00, "R7 reg5 write ignored");
        expect_b(8'h08, "R7 reg6 write ignored");
        expect_b(8'h01, "R6 reg7 write ignored");
        rd_txn(8'd0, 9);

        // shorter count, fill after exhaustion
        wr_begin(8'd8);
        wr_byte(8'h02);
        do_stop();
        expect_b(8'h02, "R9 new count header");
        expect_b(8'h12, "R3 data from index 3");
        expect_b(8'h34, "R3 data from index 4");
        expect_b(8'hFF, "R4 fill after count");
        expect_b(8'hFF, "R4 fill after count");
        rd_txn(8'd3, 5);

        // count runs out as index passes the bank end
        wr_begin(8'd8);
        wr_byte(8'h03);
        wr_byte(8'h5A);
        do_stop();
        expect_b(8'h03, "R9 count header 3");
        expect_b(8'h01, "R6 reg7 value");
        expect_b(8'h03, "R9 reg8 readback");
        expect_b(8'h00, "R11 out-of-range index reads zero");
        expect_b(8'hFF, "R4 fill after count");
        rd_txn(8'd7, 5);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule